// File: doc/BRIEF.md
# Camera Pixel Threshold Capture

This block sits directly on a parallel 8-bit camera bus and runs entirely on the camera's pixel clock. The camera sends YUV 4:2:2 data framed by a vertical sync strobe and a line-valid strobe. Inside each active line the bytes alternate luminance and chroma. The block keeps only the luminance bytes and compares each one with a programmable threshold. The result is a single mask bit per pixel, which the block writes straight into a two-bank (ping-pong) frame store together with a write address and a write strobe.

Only the write port of the frame store is driven here. The store itself, its readout and the camera's register setup live elsewhere. The bank currently being filled is shown on `wr_bank`, so the reader uses the other bank. When a frame arrives with its full pixel count, the next vertical sync flips the bank and raises a one-cycle completion pulse. A frame that ends early is thrown away: the bank does not flip and the same bank is overwritten from address zero. By default the frame is 320 x 240, which is 76800 pixels.

Top module: `cam_thresh_capture`

## Requirements
- R1: While reset is active and on the first cycle after it, `wr_en` and `frame_done` are low and `wr_bank` is 0.
- R2: Bytes are counted from 0 at each rise of `href` while `vsync` is low. Only even-numbered bytes (luminance) produce a write. Odd-numbered bytes (chroma) have no effect on any output, and writes are never on consecutive cycles.
- R3: The written bit `wr_data` is 1 when the luminance byte is greater than or equal to the latched threshold, and 0 otherwise. Both are compared as unsigned 8-bit values.
- R4: After each `vsync`, the first write uses address 0 and each later luminance byte uses the next address. Once H_PIXELS*V_LINES writes have been made, further luminance bytes in that frame are ignored. Each write appears one clock after its byte is sampled.
- R5: `thresh` is captured only on the clock where `vsync` is first seen high. Changes to it at any other time do not alter the mask bits of the frame that follows.
- R6: No write is issued on the clock after any cycle in which `vsync` is high.
- R7: If the previous frame delivered H_PIXELS*V_LINES luminance bytes, then on the clock after `vsync` rises `frame_done` is high for exactly one cycle and `wr_bank` inverts on that same clock.
- R8: If the previous frame delivered fewer luminance bytes, `vsync` produces no `frame_done` and `wr_bank` keeps its value. The next frame is written into the same bank starting at address 0. The first `vsync` after reset counts as ending such a short frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Camera pixel clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame boundary strobe, active high |
| href | input | 1 | Line-valid strobe, active high |
| pix_data | input | 8 | Camera data byte |
| thresh | input | 8 | Luminance threshold |
| wr_addr | output | ADDR_W | Pixel address within the frame store bank |
| wr_en | output | 1 | Write strobe for one mask bit |
| wr_data | output | 1 | Thresholded mask bit |
| wr_bank | output | 1 | Bank currently being written |
| frame_done | output | 1 | One-cycle pulse after a complete frame |

## Verification
The assertions take for granted that `vsync` and `href` change only between clock edges and that `href` stays low while `vsync` is high. They also assume that every rise of `href` starts with a luminance byte, so the even/odd byte count stays aligned with the pixels. The stimulus keeps to these assumptions. It holds `vsync` high for three cycles with `href` low, and it drives every line, including lines split into two bursts, as whole luminance/chroma pairs. The bench checks against a small 8 x 4 frame. It sweeps all 256 threshold values over frames of short, exact and overlong length. The luminance values land on the threshold and on either side of it, and each chroma byte is set to the inverse of the expected mask so that a chroma byte taken by mistake shows up as a data error.

// File: rtl/cam_thr_pkg.sv
package cam_thr_pkg;

  typedef enum logic {
    PH_LUMA   = 1'b0,
    PH_CHROMA = 1'b1
  } byte_phase_e;

  // unsigned comparison producing the mask bit
  function automatic logic luma_mask(input logic [15:0] luma, input logic [15:0] level);
    return (luma >= level);
  endfunction

  function automatic int frame_pixels(input int h, input int v);
    return h * v;
  endfunction

  function automatic int addr_bits(input int h, input int v);
    return $clog2(h * v + 1);
  endfunction

endpackage

// File: rtl/cam_byte_phase.sv
module cam_byte_phase
  import cam_thr_pkg::*;
(
  input  logic pclk,
  input  logic rst_n,
  input  logic vsync,
  input  logic href,
  output logic luma_strobe
);

  byte_phase_e phase_q;

  always_ff @(posedge pclk) begin
    if (!rst_n) begin
      phase_q <= PH_LUMA;
    end else if (!href || vsync) begin
      phase_q <= PH_LUMA;
    end else begin
      phase_q <= (phase_q == PH_LUMA) ? PH_CHROMA : PH_LUMA;
    end
  end

  assign luma_strobe = href && !vsync && (phase_q == PH_LUMA);

  AST_STROBE_ALTERNATES: assert property (@(posedge pclk) disable iff (!rst_n)
    luma_strobe |=> !luma_strobe); // R2

endmodule

// File: rtl/cam_frame_ctrl.sv
module cam_frame_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic [DATA_W-1:0] thresh,
  input  logic              cnt_full,
  output logic              frame_start,
  output logic [DATA_W-1:0] thr_lat,
  output logic              wr_bank,
  output logic              frame_done
);

  logic vsync_q;

  assign frame_start = vsync && !vsync_q;

  always_ff @(posedge pclk) begin
    if (!rst_n) begin
      vsync_q    <= 1'b0;
      thr_lat    <= '0;
      wr_bank    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      vsync_q    <= vsync;
      frame_done <= 1'b0;
      if (frame_start) begin
        thr_lat <= thresh;
        if (cnt_full) begin
          wr_bank    <= !wr_bank;
          frame_done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7

  AST_BANK_ONLY_ON_DONE: assert property (@(posedge pclk) disable iff (!rst_n)
    (wr_bank != $past(wr_bank)) |-> frame_done); // R8

  AST_DONE_FLIPS_BANK: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |-> (wr_bank != $past(wr_bank))); // R7

  AST_THR_HELD: assert property (@(posedge pclk) disable iff (!rst_n)
    !frame_start |=> $stable(thr_lat)); // R5

endmodule

// File: rtl/cam_pix_writer.sv
module cam_pix_writer
  import cam_thr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PIX    = 76800,
  parameter int ADDR_W = 17
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              luma_strobe,
  input  logic [DATA_W-1:0] pix_data,
  input  logic [DATA_W-1:0] thr_lat,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic              wr_data,
  output logic              cnt_full
);

  localparam logic [ADDR_W-1:0] LAST_CNT = ADDR_W'(PIX);

  logic [ADDR_W-1:0] cnt_q;
  logic              take;

  assign cnt_full = (cnt_q == LAST_CNT);
  assign take     = luma_strobe && !cnt_full;

  always_ff @(posedge pclk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wr_addr <= '0;
      wr_en   <= 1'b0;
      wr_data <= 1'b0;
    end else if (vsync) begin
      cnt_q <= '0;
      wr_en <= 1'b0;
    end else begin
      wr_en <= take;
      if (take) begin
        wr_addr <= cnt_q;
        wr_data <= luma_mask(16'(pix_data), 16'(thr_lat));
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge pclk) disable iff (!rst_n)
    wr_en |-> (wr_addr < LAST_CNT)); // R4

  AST_NO_WRITE_IN_VSYNC: assert property (@(posedge pclk) disable iff (!rst_n)
    vsync |=> !wr_en); // R6

  AST_NO_BACK_TO_BACK: assert property (@(posedge pclk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R2

endmodule

// File: rtl/cam_thresh_capture.sv
module cam_thresh_capture
  import cam_thr_pkg::*;
#(
  parameter int H_PIXELS = 320,
  parameter int V_LINES  = 240,
  parameter int ADDR_W   = addr_bits(H_PIXELS, V_LINES)
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              href,
  input  logic [7:0]        pix_data,
  input  logic [7:0]        thresh,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic              wr_data,
  output logic              wr_bank,
  output logic              frame_done
);

  localparam int DATA_W = 8;
  localparam int PIX    = frame_pixels(H_PIXELS, V_LINES);

  // internal events, named for the assertions
  logic              luma_strobe;
  logic              frame_start;
  logic              cnt_full;
  logic [DATA_W-1:0] thr_lat;

  cam_byte_phase u_phase (
    .pclk        (pclk),
    .rst_n       (rst_n),
    .vsync       (vsync),
    .href        (href),
    .luma_strobe (luma_strobe)
  );

  cam_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .pclk        (pclk),
    .rst_n       (rst_n),
    .vsync       (vsync),
    .thresh      (thresh),
    .cnt_full    (cnt_full),
    .frame_start (frame_start),
    .thr_lat     (thr_lat),
    .wr_bank     (wr_bank),
    .frame_done  (frame_done)
  );

  cam_pix_writer #(.DATA_W(DATA_W), .PIX(PIX), .ADDR_W(ADDR_W)) u_writer (
    .pclk        (pclk),
    .rst_n       (rst_n),
    .vsync       (vsync),
    .luma_strobe (luma_strobe),
    .pix_data    (pix_data),
    .thr_lat     (thr_lat),
    .wr_addr     (wr_addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .cnt_full    (cnt_full)
  );

  AST_DONE_NEEDS_START: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |-> $past(frame_start)); // R7

endmodule

// File: tb/sim_cam_thresh_capture.sv
module sim_cam_thresh_capture;

  localparam int CLK_PERIOD = 10;
  localparam int HP  = 8;
  localparam int VL  = 4;
  localparam int PIX = HP * VL;
  localparam int AW  = $clog2(PIX + 1);

  logic          pclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vsync = 1'b0;
  logic          href = 1'b0;
  logic [7:0]    pix_data = '0;
  logic [7:0]    thresh = '0;
  logic [AW-1:0] wr_addr;
  logic          wr_en;
  logic          wr_data;
  logic          wr_bank;
  logic          frame_done;

  cam_thresh_capture #(.H_PIXELS(HP), .V_LINES(VL)) u0 (
    .pclk(pclk), .rst_n(rst_n), .vsync(vsync), .href(href),
    .pix_data(pix_data), .thresh(thresh), .wr_addr(wr_addr),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bank(wr_bank),
    .frame_done(frame_done)
  );

  always #(CLK_PERIOD / 2) pclk = ~pclk;

  int   checks = 0;
  int   fails = 0;
  int   wcnt = 0;
  int   done_cnt = 0;
  int   exp_done = 0;
  logic exp_bank = 1'b0;
  logic done_prev = 1'b0;
  logic vs_prev = 1'b0;
  logic exp_mask [PIX];
  bit   prev_complete = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ypix(input int f, input int p, input int thr);
    logic [7:0] t;
    t = 8'(thr);
    if (p == 0) return t;
    if (p == 1) return t - 8'd1;
    if (p == 2) return t + 8'd1;
    return 8'((p * 29 + f * 7) & 255);
  endfunction

  // monitor, sampling away from the active edge
  always @(negedge pclk) begin
    if (rst_n) begin
      if (wr_en) begin
        chk(wcnt < PIX, "R4 write beyond frame", wcnt, PIX - 1);
        chk(int'(wr_addr) == wcnt, "R4 address", int'(wr_addr), wcnt);
        if (wcnt < PIX)
          chk(wr_data == exp_mask[wcnt], "R3 mask bit", int'(wr_data), int'(exp_mask[wcnt]));
        chk(wr_bank == exp_bank, "R8 write bank", int'(wr_bank), int'(exp_bank));
        wcnt++;
      end
      if (vsync && vs_prev)
        chk(!wr_en, "R6 write during vsync", int'(wr_en), 0);
      if (frame_done) done_cnt++;
      if (frame_done && done_prev)
        chk(1'b0, "R7 done wider than one cycle", 2, 1);
      done_prev = frame_done;
      vs_prev   = vsync;
      if (vsync) wcnt = 0;
    end
  end

  task automatic tick;
    @(posedge pclk);
    #1;
  endtask

  // vsync pulse ending the previous frame and starting the next
  task automatic frame_boundary(input int f, input int thr);
    href   = 1'b0;
    vsync  = 1'b1;
    thresh = 8'(thr);
    tick;
    // past the last write of the old frame: new expectations
    for (int p = 0; p < PIX; p++) exp_mask[p] = (ypix(f, p, thr) >= 8'(thr));
    thresh = 8'(thr) ^ 8'h5A;   // R5: not latched
    tick;
    tick;
    if (prev_complete) begin
      exp_done++;
      exp_bank = ~exp_bank;
    end
    chk(done_cnt == exp_done, prev_complete ? "R7 done count" : "R8 done count",
        done_cnt, exp_done);
    chk(wr_bank == exp_bank, prev_complete ? "R7 bank toggle" : "R8 bank held",
        int'(wr_bank), int'(exp_bank));
    vsync = 1'b0;
    tick;
  endtask

  task automatic send_burst(input int f, input int thr, input int p0, input int n);
    for (int x = 0; x < n; x++) begin
      logic [7:0] y;
      y = ypix(f, p0 + x, thr);
      href = 1'b1;
      pix_data = y;
      tick;
      pix_data = (y >= 8'(thr)) ? 8'h00 : 8'hFF;   // R2: chroma is inverse
      thresh = thresh + 8'd3;                       // R5: mid-frame change
      tick;
    end
    href = 1'b0;
    pix_data = 8'hFF;
    tick;
    tick;
  endtask

  task automatic send_frame(input int f, input int thr, input int lines, input bit split);
    int exp_w;
    frame_boundary(f, thr);
    for (int l = 0; l < lines; l++) begin
      if (split) begin
        send_burst(f, thr, l * HP, HP / 2);
        send_burst(f, thr, l * HP + HP / 2, HP - HP / 2);
      end else begin
        send_burst(f, thr, l * HP, HP);
      end
    end
    tick;
    exp_w = (lines * HP < PIX) ? lines * HP : PIX;
    chk(wcnt == exp_w, "R4 writes per frame", wcnt, exp_w);
    prev_complete = (lines * HP >= PIX);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) tick;
    chk(!wr_en && !frame_done && !wr_bank, "R1 outputs in reset",
        int'({wr_en, frame_done, wr_bank}), 0);
    rst_n = 1'b1;
    tick;
    chk(!wr_en && !frame_done && !wr_bank, "R1 outputs after reset",
        int'({wr_en, frame_done, wr_bank}), 0);
    // all 256 thresholds; short, exact and overlong frames; split lines
    for (int f = 0; f < 256; f++) begin
      int lines;
      lines = (f % 8 == 6) ? VL - 1 : ((f % 8 == 7) ? VL + 1 : VL);
      send_frame(f, f, lines, (f % 3) == 0);
    end
    frame_boundary(0, 0);
    repeat (3) tick;
    chk(done_cnt == exp_done, "R7 final done count", done_cnt, exp_done);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule